// File: doc/BRIEF.md
# Code Transition Calibration Monitor

This block watches a stream of 12-bit offset-binary converter codes while a steady trim voltage is applied and the converter samples without pause. It counts how often each of two neighbouring target codes turns up over a window with a programmable number of samples. When the window closes it reports one of four results: the two codes are balanced, the codes lean toward the lower one, the codes lean toward the upper one, or the samples are mostly not target codes at all. A controller reads this result, or a person watches two indicator outputs, and moves the trim until the result is balanced.

There are two targets. In offset mode the lower target is mid-scale, 0x800, and the upper target is 0x801. In gain mode the lower target is 0xFFE and the upper target is 0xFFF, just below full scale. Offset is trimmed first. A gain request takes effect only after an offset window has ended balanced with no stall, or when an override input is high.

The sample input is valid/ready. The block only observes the stream, so it never applies back-pressure: ready stays high and every cycle with valid high delivers one sample. If no sample arrives for a programmed number of cycles, the current window is marked stale.

Top module: `code_trim_monitor`

## Requirements
- R1: `smp_ready` is 1 in every cycle out of reset, and each cycle with `smp_valid` high delivers exactly one sample.
- R2: While `gain_active` is 0, code 0x800 counts as the lower target and 0x801 as the upper target. While `gain_active` is 1, 0xFFE counts as the lower target and 0xFFF as the upper target. Every other code counts as off-target.
- R3: A window closes on the sample that brings the sample count to `win_len`, and a `win_len` of 0 behaves as 1. In the cycle after that sample's edge, `res_valid` is 1 for exactly one cycle and `cnt_lo`, `cnt_hi` and `cnt_off` hold the three counts for that window, including that sample. These outputs keep their values until the next window closes, and counting then starts again from zero.
- R4: `verdict` is 0 (balanced) when |cnt_lo − cnt_hi| ≤ `tol` and the off-target rule of R6 does not apply.
- R5: When the window is neither off-target nor balanced, `verdict` is 1 (low) if cnt_lo > cnt_hi, and 2 (high) if cnt_hi > cnt_lo.
- R6: `verdict` is 3 (off target) when twice cnt_off is greater than the window's sample count. This rule takes priority over R4 and R5.
- R7: With `gap_limit` nonzero, `gap_limit` consecutive cycles without a sample mark the current window stale. `res_stale` is updated together with the results of R3. A `gap_limit` of 0 turns stall detection off.
- R8: `offset_done` becomes 1 when a window closes with `gain_active` = 0, `verdict` = 0 and `res_stale` = 0. It then stays 1 until reset.
- R9: `gain_active` is the value of `mode_gain & (offset_done | gain_override)` registered one cycle earlier. A gain request made before that condition holds has no effect.
- R10: Any change of `gain_active` restarts the window. The partial counts, the stall flag and any sample taken in that cycle are discarded.
- R11: `led_one` equals bit 0 of the most recent target-code sample and `led_zero` is its inverse. Off-target samples and discarded samples leave both unchanged.
- R12: After reset all outputs are 0 except `smp_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | A sample is present |
| smp_ready | output | 1 | Always 1; the block never stalls the stream |
| smp_code | input | 12 | Offset-binary converter code |
| mode_gain | input | 1 | 0 selects offset targets, 1 requests gain targets |
| gain_override | input | 1 | Allows gain mode without a balanced offset result |
| win_len | input | 16 | Samples per window (0 acts as 1) |
| tol | input | 16 | Largest count difference still judged balanced |
| gap_limit | input | 16 | Idle cycles that mark a window stale (0 = off) |
| res_valid | output | 1 | One-cycle pulse when a window's results are updated |
| cnt_lo | output | 16 | Lower-target count of the last window |
| cnt_hi | output | 16 | Upper-target count of the last window |
| cnt_off | output | 16 | Off-target count of the last window |
| verdict | output | 2 | 0 balanced, 1 low, 2 high, 3 off target |
| res_stale | output | 1 | The last window saw a stall |
| offset_done | output | 1 | Sticky: a clean, balanced offset window has been seen |
| gain_active | output | 1 | Gain targets are in use |
| led_one | output | 1 | Bit 0 of the last target sample |
| led_zero | output | 1 | Inverse of bit 0 of the last target sample |

## Verification
The window-total and balance properties assume that `win_len` and `tol` stay constant while a window is open. The bench changes them only in idle gaps right after a window has closed, or while reset is held. The stream needs no handshake assumptions because ready never falls. The stimulus creates stalls on purpose and switches modes in the middle of a window to exercise the stale and restart paths. The reference model advances on every clock from the bench's own inputs alone.

// File: rtl/ctm_pkg.sv
package ctm_pkg;
  typedef enum logic [1:0] {
    V_BAL  = 2'd0,
    V_LOW  = 2'd1,
    V_HIGH = 2'd2,
    V_OFF  = 2'd3
  } verdict_e;
endpackage

// File: rtl/ctm_classify.sv
module ctm_classify #(
  parameter int DW = 12
) (
  input  logic [DW-1:0] code,
  input  logic          gain,
  output logic          is_lo,
  output logic          is_hi
);
  localparam logic [DW-1:0] MID = DW'(1) << (DW - 1);
  localparam logic [DW-1:0] TOP = '1;

  logic [DW-1:0] lo_code, hi_code;
  assign lo_code = gain ? (TOP - DW'(1)) : MID;
  assign hi_code = gain ? TOP : (MID + DW'(1));
  assign is_lo = (code == lo_code);
  assign is_hi = (code == hi_code);
endmodule

// File: rtl/ctm_judge.sv
module ctm_judge
  import ctm_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic [CW-1:0] lo,
  input  logic [CW-1:0] hi,
  input  logic [CW-1:0] off,
  input  logic [CW-1:0] total,
  input  logic [CW-1:0] tol,
  output verdict_e      verdict
);
  logic [CW:0]   off_x2;
  logic [CW-1:0] diff;
  assign off_x2 = {off, 1'b0};
  assign diff   = (lo > hi) ? (lo - hi) : (hi - lo);

  always_comb begin
    if (off_x2 > {1'b0, total})  verdict = V_OFF;
    else if (diff <= tol)        verdict = V_BAL;
    else if (lo > hi)            verdict = V_LOW;
    else                         verdict = V_HIGH;
  end
endmodule

// File: rtl/ctm_window.sv
module ctm_window #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          fire,
  input  logic          is_lo,
  input  logic          is_hi,
  input  logic [CW-1:0] win_len,
  input  logic [CW-1:0] gap_limit,
  output logic          fin,
  output logic [CW-1:0] lo_n,
  output logic [CW-1:0] hi_n,
  output logic [CW-1:0] off_n,
  output logic [CW-1:0] tot_n,
  output logic          gap_q
);
  logic [CW-1:0] lo_q, hi_q, off_q, n_q, idle_q, idle_inc, win_eff;
  logic          gap_hit, is_off;

  assign is_off   = ~is_lo & ~is_hi;
  assign tot_n    = n_q + CW'(1);
  assign lo_n     = lo_q  + CW'(is_lo);
  assign hi_n     = hi_q  + CW'(is_hi);
  assign off_n    = off_q + CW'(is_off);
  assign win_eff  = (win_len == '0) ? CW'(1) : win_len;
  assign fin      = fire & ~restart & (tot_n >= win_eff);
  assign idle_inc = (idle_q == '1) ? idle_q : idle_q + CW'(1);
  assign gap_hit  = ~fire & (gap_limit != '0) & (idle_inc >= gap_limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0; hi_q <= '0; off_q <= '0; n_q <= '0;
      idle_q <= '0; gap_q <= 1'b0;
    end else if (restart) begin
      lo_q <= '0; hi_q <= '0; off_q <= '0; n_q <= '0;
      idle_q <= '0; gap_q <= 1'b0;
    end else if (fire) begin
      idle_q <= '0;
      if (fin) begin
        lo_q <= '0; hi_q <= '0; off_q <= '0; n_q <= '0;
        gap_q <= 1'b0;
      end else begin
        lo_q <= lo_n; hi_q <= hi_n; off_q <= off_n; n_q <= tot_n;
      end
    end else begin
      idle_q <= idle_inc;
      if (gap_hit) gap_q <= 1'b1;
    end
  end
endmodule

// File: rtl/code_trim_monitor.sv
module code_trim_monitor
  import ctm_pkg::*;
#(
  parameter int DW = 12,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  output logic          smp_ready,
  input  logic [DW-1:0] smp_code,
  input  logic          mode_gain,
  input  logic          gain_override,
  input  logic [CW-1:0] win_len,
  input  logic [CW-1:0] tol,
  input  logic [CW-1:0] gap_limit,
  output logic          res_valid,
  output logic [CW-1:0] cnt_lo,
  output logic [CW-1:0] cnt_hi,
  output logic [CW-1:0] cnt_off,
  output logic [1:0]    verdict,
  output logic          res_stale,
  output logic          offset_done,
  output logic          gain_active,
  output logic          led_one,
  output logic          led_zero
);
  logic          fire, restart, ga_d, is_lo, is_hi, fin, gap_q;
  logic [CW-1:0] lo_n, hi_n, off_n, tot_n;
  verdict_e      v_n;

  assign smp_ready = 1'b1;
  assign fire      = smp_valid & smp_ready;
  assign ga_d      = mode_gain & (offset_done | gain_override);
  assign restart   = ga_d ^ gain_active;

  ctm_classify #(.DW(DW)) u_cls (
    .code(smp_code), .gain(gain_active), .is_lo(is_lo), .is_hi(is_hi)
  );

  ctm_window #(.CW(CW)) u_win (
    .clk(clk), .rst_n(rst_n), .restart(restart), .fire(fire),
    .is_lo(is_lo), .is_hi(is_hi), .win_len(win_len), .gap_limit(gap_limit),
    .fin(fin), .lo_n(lo_n), .hi_n(hi_n), .off_n(off_n), .tot_n(tot_n),
    .gap_q(gap_q)
  );

  ctm_judge #(.CW(CW)) u_jdg (
    .lo(lo_n), .hi(hi_n), .off(off_n), .total(tot_n), .tol(tol),
    .verdict(v_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0; cnt_lo <= '0; cnt_hi <= '0; cnt_off <= '0;
      verdict <= 2'd0; res_stale <= 1'b0; offset_done <= 1'b0;
      gain_active <= 1'b0; led_one <= 1'b0; led_zero <= 1'b0;
    end else begin
      res_valid   <= fin;
      gain_active <= ga_d;
      if (fin) begin
        cnt_lo    <= lo_n;
        cnt_hi    <= hi_n;
        cnt_off   <= off_n;
        verdict   <= v_n;
        res_stale <= gap_q;
        if (!gain_active && v_n == V_BAL && !gap_q) offset_done <= 1'b1;
      end
      if (fire && !restart && (is_lo || is_hi)) begin
        led_one  <= smp_code[0];
        led_zero <= ~smp_code[0];
      end
    end
  end
endmodule

// File: rtl/ctm_checker.sv
module ctm_checker #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          smp_ready,
  input logic          mode_gain,
  input logic          gain_override,
  input logic [CW-1:0] win_len,
  input logic [CW-1:0] tol,
  input logic          res_valid,
  input logic [CW-1:0] cnt_lo,
  input logic [CW-1:0] cnt_hi,
  input logic [CW-1:0] cnt_off,
  input logic [1:0]    verdict,
  input logic          offset_done,
  input logic          gain_active,
  input logic          led_one,
  input logic          led_zero
);
  logic [CW+1:0] sum3, win_exp;
  logic [CW-1:0] adiff;
  assign sum3    = {2'b0, cnt_lo} + {2'b0, cnt_hi} + {2'b0, cnt_off};
  assign win_exp = (win_len == '0) ? (CW+2)'(1) : {2'b0, win_len};
  assign adiff   = (cnt_lo > cnt_hi) ? (cnt_lo - cnt_hi) : (cnt_hi - cnt_lo);

  a_r1_ready_high: assert property (@(posedge clk) disable iff (!rst_n)
    smp_ready);
  a_r3_window_total: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> sum3 == win_exp);
  a_r4_balanced_in_tol: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && verdict == 2'd0) |-> adiff <= tol);
  a_r5_low_direction: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && verdict == 2'd1) |-> cnt_lo > cnt_hi);
  a_r6_off_majority: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && verdict == 2'd3) |-> ({1'b0, cnt_off, 1'b0} > win_exp));
  a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    offset_done |=> offset_done);
  a_r9_gain_gated: assert property (@(posedge clk) disable iff (!rst_n)
    gain_active |-> $past(mode_gain && (offset_done || gain_override)));
  a_r11_led_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(led_one && led_zero));
endmodule

bind code_trim_monitor ctm_checker #(.CW(CW)) u_ctm_checker (
  .clk(clk), .rst_n(rst_n), .smp_ready(smp_ready), .mode_gain(mode_gain),
  .gain_override(gain_override), .win_len(win_len), .tol(tol),
  .res_valid(res_valid), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .cnt_off(cnt_off),
  .verdict(verdict), .offset_done(offset_done), .gain_active(gain_active),
  .led_one(led_one), .led_zero(led_zero)
);

// File: tb/code_trim_monitor_test.sv
module code_trim_monitor_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic [11:0] smp_code = '0;
  logic mode_gain = 1'b0, gain_override = 1'b0;
  logic [15:0] win_len = 16'd8, tol = '0, gap_limit = '0;
  logic smp_ready, res_valid, res_stale, offset_done, gain_active, led_one, led_zero;
  logic [15:0] cnt_lo, cnt_hi, cnt_off;
  logic [1:0] verdict;

  int nchk = 0, nfail = 0;

  always #5 clk = ~clk;

  code_trim_monitor uut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_code(smp_code), .mode_gain(mode_gain), .gain_override(gain_override),
    .win_len(win_len), .tol(tol), .gap_limit(gap_limit), .res_valid(res_valid),
    .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .cnt_off(cnt_off), .verdict(verdict),
    .res_stale(res_stale), .offset_done(offset_done), .gain_active(gain_active),
    .led_one(led_one), .led_zero(led_zero)
  );

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  int m_lo, m_hi, m_off, m_n, m_idle, m_gap;
  int e_rv, e_lo, e_hi, e_off, e_v, e_stale, e_done, e_ga, e_l1, e_l0;
  int o_lo, o_hi, o_off, o_v, o_stale;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lo = 0; m_hi = 0; m_off = 0; m_n = 0; m_idle = 0; m_gap = 0;
      e_rv = 0; e_lo = 0; e_hi = 0; e_off = 0; e_v = 0; e_stale = 0;
      e_done = 0; e_ga = 0; e_l1 = 0; e_l0 = 0;
    end else begin
      int ga_next, lo_c, hi_c, w, d, c;
      ga_next = (mode_gain && (e_done != 0 || gain_override)) ? 1 : 0;
      e_rv = 0;
      if (ga_next != e_ga) begin
        m_lo = 0; m_hi = 0; m_off = 0; m_n = 0; m_idle = 0; m_gap = 0;
      end else if (smp_valid) begin
        c = smp_code;
        lo_c = e_ga ? 'hFFE : 'h800;
        hi_c = e_ga ? 'hFFF : 'h801;
        if (c == lo_c) m_lo++;
        else if (c == hi_c) m_hi++;
        else m_off++;
        if (c == lo_c || c == hi_c) begin
          e_l1 = c % 2; e_l0 = 1 - (c % 2);
        end
        m_n++;
        m_idle = 0;
        w = (win_len == 0) ? 1 : int'(win_len);
        if (m_n >= w) begin
          d = (m_lo > m_hi) ? m_lo - m_hi : m_hi - m_lo;
          if (2 * m_off > m_n) e_v = 3;
          else if (d <= int'(tol)) e_v = 0;
          else if (m_lo > m_hi) e_v = 1;
          else e_v = 2;
          e_rv = 1; e_lo = m_lo; e_hi = m_hi; e_off = m_off; e_stale = m_gap;
          if (e_ga == 0 && e_v == 0 && m_gap == 0) e_done = 1;
          m_lo = 0; m_hi = 0; m_off = 0; m_n = 0; m_gap = 0;
        end
      end else begin
        if (m_idle < 65535) m_idle++;
        if (gap_limit != 0 && m_idle >= int'(gap_limit)) m_gap = 1;
      end
      e_ga = ga_next;
    end
  end

  // Per-cycle comparison, away from the edge
  always begin
    @(posedge clk);
    #2;
    chk("R1 ready", int'(smp_ready), 1);
    chk("R3 res_valid", int'(res_valid), e_rv);
    chk("R2/R3/R10 cnt_lo", int'(cnt_lo), e_lo);
    chk("R2/R3/R10 cnt_hi", int'(cnt_hi), e_hi);
    chk("R2/R3/R10 cnt_off", int'(cnt_off), e_off);
    chk("R4/R5/R6 verdict", int'(verdict), e_v);
    chk("R7 res_stale", int'(res_stale), e_stale);
    chk("R8 offset_done", int'(offset_done), e_done);
    chk("R9 gain_active", int'(gain_active), e_ga);
    chk("R11 led_one", int'(led_one), e_l1);
    chk("R11 led_zero", int'(led_zero), e_l0);
    if (res_valid) begin
      o_lo = cnt_lo; o_hi = cnt_hi; o_off = cnt_off; o_v = verdict; o_stale = res_stale;
    end
  end

  task automatic push(int c, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      smp_valid = 1'b1;
      smp_code = 12'(c);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      smp_valid = 1'b0;
    end
  endtask

  task automatic do_reset(logic ovr, logic mg);
    @(negedge clk);
    rst_n = 1'b0; smp_valid = 1'b0;
    gain_override = ovr; mode_gain = mg;
    win_len = 16'd8; tol = '0; gap_limit = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset(1'b0, 1'b1);
    // R12 reset state
    chk("R12 res_valid", int'(res_valid), 0);
    chk("R12 counts", int'(cnt_lo) + int'(cnt_hi) + int'(cnt_off), 0);
    chk("R12 flags", int'(offset_done) + int'(gain_active) + int'(led_one) + int'(led_zero), 0);
    chk("R1 ready", int'(smp_ready), 1);
    // gain requested too early: top codes are off target
    push('hFFF, 8); idle(3);
    chk("R6 verdict off", o_v, 3);
    chk("R2 off count", o_off, 8);
    chk("R9 gain blocked", int'(gain_active), 0);
    mode_gain = 1'b0;
    push('h800, 5); push('h801, 3); idle(3);
    chk("R5 verdict low", o_v, 1);
    chk("R2 lo count", o_lo, 5);
    chk("R8 not done", int'(offset_done), 0);
    push('h800, 2); push('h801, 6); idle(3);
    chk("R5 verdict high", o_v, 2);
    tol = 16'd1; gap_limit = 16'd4;
    push('h800, 4); idle(6); push('h801, 4); idle(3);
    chk("R7 stale", o_stale, 1);
    chk("R4 balanced", o_v, 0);
    chk("R8 stale blocks done", int'(offset_done), 0);
    gap_limit = '0;
    push('h800, 2); push('h801, 2); push('h800, 2); push('h801, 2); idle(3);
    chk("R7 clean", o_stale, 0);
    chk("R8 done", int'(offset_done), 1);
    mode_gain = 1'b1; idle(2);
    chk("R9 gain active", int'(gain_active), 1);
    tol = 16'd2;
    push('hFFE, 4); push('hFFF, 3); push('h800, 1); idle(3);
    chk("R2 gain lo", o_lo, 4);
    chk("R2 gain hi", o_hi, 3);
    chk("R4 gain balanced", o_v, 0);
    push('hFFF, 3);
    @(negedge clk); smp_valid = 1'b0; mode_gain = 1'b0;
    idle(2);
    push('h801, 8); idle(3);
    chk("R10 hi only new", o_hi, 8);
    chk("R10 lo discarded", o_lo, 0);
    chk("R10 verdict", o_v, 2);
    win_len = '0;
    push('h800, 1); idle(3);
    chk("R3 single window lo", o_lo, 1);
    chk("R3 single window off", o_off, 0);
    chk("R11 led_one", int'(led_one), 0);
    chk("R11 led_zero", int'(led_zero), 1);
    push('h123, 1); idle(2);
    chk("R11 off-target ignored", int'(led_zero), 1);
    push('h801, 1); idle(2);
    chk("R11 led_one set", int'(led_one), 1);
    do_reset(1'b1, 1'b1);
    idle(2);
    chk("R9 override", int'(gain_active), 1);
    push('hFFE, 4); push('hFFF, 4); idle(3);
    chk("R4 override balanced", o_v, 0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    #1500000;
    nchk++; nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule